// File: doc/BRIEF.md
# Two-Wiring Cartridge Bank Mapper

This block translates CPU and graphics-bus addresses into banked memory addresses for a cartridge holding up to four 32KB program banks and a set of 4KB pattern banks. The CPU sees one 32KB program window in the upper half of its address space. The mapper selects which physical bank fills that window. A static strap picks one of two board wirings, and another static strap relaxes the register-file wiring for compatibility.

In the discrete wiring, any CPU write to the upper half loads the program bank register. The CPU byte and the ROM byte both drive the data bus during that write, so the value loaded is their bitwise AND. The pattern space is one flat 8KB writable region, and there is no work RAM. In the register-file wiring, an 8KB work RAM sits at 0x6000–0x7FFF. Its three highest bytes double as bank registers: 0x7FFD selects the program bank, 0x7FFE selects the lower pattern window and 0x7FFF selects the upper pattern window. The pattern space is then two independently banked 4KB windows.

All bank numbers are reduced modulo the number of banks present. The memory arrays sit outside the block and use the enables and addresses it produces.

Top module: `cart_bank_mapper`

## Requirements
- R1: `prgRomAddr` is the program bank in the bits above bit 14 and `cpuAddr[14:0]` below it. `prgRomEn` is high when `cpuAddr[15]` is 1 and either `cpuWr` is 0 or the discrete wiring is selected (`modeRegFile`=0).
- R2: In the discrete wiring, a write anywhere in 0x8000–0xFFFF loads the program bank with `cpuData & romData`, taken modulo `PRG_BANKS`.
- R3: In the discrete wiring, `wramEn` stays 0 and writes to 0x6000–0x7FFF leave the bank state unchanged. Also, `chrAddr` equals `ppuAddr` zero-extended, and `chrRamWe` follows `ppuWr`.
- R4: In the register-file wiring with `compatEn`=0, a write to 0x7FFD loads the program bank with bit 0 of the byte only.
- R5: In the register-file wiring, a write to 0x7FFE sets the bank for pattern addresses with `ppuAddr[12]`=0, and a write to 0x7FFF sets the bank for `ppuAddr[12]`=1. Each value is taken modulo `CHR_BANKS`. `chrAddr` is that bank above `ppuAddr[11:0]`, and `chrRamWe` stays 0. A write to 0x7FFF leaves the program bank unchanged.
- R6: In the register-file wiring, `wramEn` is high for every address in 0x6000–0x7FFF, including the three register addresses, so register writes also reach the RAM. It is low elsewhere.
- R7: In the register-file wiring with `compatEn`=0, writes to 0x8000–0xFFFF leave the program bank unchanged.
- R8: In the register-file wiring with `compatEn`=1, a write to 0x7FFD, or anywhere in 0x8000–0xFFFF, loads the program bank with the full byte modulo `PRG_BANKS`, without ANDing it with `romData`.
- R9: Reset sets the program bank to 0, the lower pattern bank to 0 and the upper pattern bank to 1.
- R10: Bank registers change only at a rising clock edge where `cpuWr` is 1. Holding an address and data with `cpuWr` at 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeRegFile | input | 1 | Static wiring select: 0 selects discrete, 1 selects register file |
| compatEn | input | 1 | Static compatibility relaxation for the register-file wiring |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| cpuWr | input | 1 | CPU write strobe |
| romData | input | 8 | ROM byte currently visible at `cpuAddr` |
| ppuAddr | input | 13 | Pattern-space address |
| ppuWr | input | 1 | Pattern-space write strobe |
| prgRomAddr | output | PRGW+15 | Banked program ROM address |
| prgRomEn | output | 1 | Program ROM enable |
| wramEn | output | 1 | Work RAM enable |
| chrAddr | output | CHRW+12 | Pattern memory address |
| chrRamWe | output | 1 | Pattern RAM write enable |

## Verification
The assertions assume that `modeRegFile` and `compatEn` are held constant whenever reset is released. They also assume that `romData` is valid in any cycle where a discrete upper-half write is strobed. The bench changes both straps only while `rstN` is low. It drives `romData` together with every CPU write, and it places each input change on the falling clock edge. This keeps the values captured at the rising edge well defined.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam logic [15:0] REG_PRG    = 16'h7FFD;
  localparam logic [15:0] REG_CHR_LO = 16'h7FFE;
  localparam logic [15:0] REG_CHR_HI = 16'h7FFF;

  typedef enum logic [1:0] {
    PRG_SRC_BIT0 = 2'd0,
    PRG_SRC_FULL = 2'd1,
    PRG_SRC_AND  = 2'd2
  } prgSrc_e;

  typedef struct packed {
    logic    loadPrg;
    prgSrc_e prgSrc;
    logic [1:0] loadChr;
  } bankStrobe_t;
endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import cbm_pkg::*;
(
  input  logic        modeRegFile,
  input  logic        compatEn,
  input  logic [15:0] cpuAddr,
  input  logic        cpuWr,
  input  logic        ppuWr,
  output bankStrobe_t strobe,
  output logic        prgRomEn,
  output logic        wramEn,
  output logic        chrRamWe
);
  logic upperHalf;
  logic wramWindow;

  assign upperHalf  = cpuAddr[15];
  assign wramWindow = (cpuAddr[15:13] == 3'b011);

  always_comb begin
    strobe = '0;
    strobe.prgSrc = PRG_SRC_AND;
    if (cpuWr) begin
      if (!modeRegFile) begin
        if (upperHalf) begin
          strobe.loadPrg = 1'b1;
          strobe.prgSrc  = PRG_SRC_AND;
        end
      end else begin
        if (cpuAddr == REG_PRG) begin
          strobe.loadPrg = 1'b1;
          strobe.prgSrc  = compatEn ? PRG_SRC_FULL : PRG_SRC_BIT0;
        end else if (cpuAddr == REG_CHR_LO) begin
          strobe.loadChr[0] = 1'b1;
        end else if (cpuAddr == REG_CHR_HI) begin
          strobe.loadChr[1] = 1'b1;
        end else if (upperHalf && compatEn) begin
          strobe.loadPrg = 1'b1;
          strobe.prgSrc  = PRG_SRC_FULL;
        end
      end
    end
  end

  assign prgRomEn = upperHalf && (!cpuWr || !modeRegFile);
  assign wramEn   = modeRegFile && wramWindow;
  assign chrRamWe = !modeRegFile && ppuWr;
endmodule

// File: rtl/mapper_dpath.sv
module mapper_dpath
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 4,
  parameter int CHR_BANKS = 16,
  localparam int PRGW   = $clog2(PRG_BANKS),
  localparam int CHRW   = $clog2(CHR_BANKS),
  localparam int PRG_AW = PRGW + 15,
  localparam int CHR_AW = CHRW + 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeRegFile,
  input  bankStrobe_t       strobe,
  input  logic [14:0]       cpuOffset,
  input  logic [7:0]        cpuData,
  input  logic [7:0]        romData,
  input  logic [12:0]       ppuAddr,
  output logic [PRG_AW-1:0] prgRomAddr,
  output logic [CHR_AW-1:0] chrAddr
);
  logic [7:0]      prgNext;
  logic [PRGW-1:0] prgBank;
  logic [CHRW-1:0] chrBank [2];

  always_comb begin
    case (strobe.prgSrc)
      PRG_SRC_BIT0: prgNext = {7'b0, cpuData[0]};
      PRG_SRC_FULL: prgNext = cpuData;
      default:      prgNext = cpuData & romData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               prgBank <= '0;
    else if (strobe.loadPrg) prgBank <= prgNext[PRGW-1:0];
  end

  for (genvar w = 0; w < 2; w++) begin : g_chrWin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  chrBank[w] <= CHRW'(w);
      else if (strobe.loadChr[w]) chrBank[w] <= cpuData[CHRW-1:0];
    end
  end

  assign prgRomAddr = {prgBank, cpuOffset};
  assign chrAddr    = modeRegFile ? {chrBank[ppuAddr[12]], ppuAddr[11:0]}
                                  : CHR_AW'(ppuAddr);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int PRG_BANKS = 4,
  parameter int CHR_BANKS = 16,
  localparam int PRGW   = $clog2(PRG_BANKS),
  localparam int CHRW   = $clog2(CHR_BANKS),
  localparam int PRG_AW = PRGW + 15,
  localparam int CHR_AW = CHRW + 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeRegFile,
  input  logic              compatEn,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuData,
  input  logic              cpuWr,
  input  logic [7:0]        romData,
  input  logic [12:0]       ppuAddr,
  input  logic              ppuWr,
  output logic [PRG_AW-1:0] prgRomAddr,
  output logic              prgRomEn,
  output logic              wramEn,
  output logic [CHR_AW-1:0] chrAddr,
  output logic              chrRamWe
);
  bankStrobe_t strobe;

  mapper_ctrl u_ctrl (
    .modeRegFile(modeRegFile),
    .compatEn   (compatEn),
    .cpuAddr    (cpuAddr),
    .cpuWr      (cpuWr),
    .ppuWr      (ppuWr),
    .strobe     (strobe),
    .prgRomEn   (prgRomEn),
    .wramEn     (wramEn),
    .chrRamWe   (chrRamWe)
  );

  mapper_dpath #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .modeRegFile(modeRegFile),
    .strobe     (strobe),
    .cpuOffset  (cpuAddr[14:0]),
    .cpuData    (cpuData),
    .romData    (romData),
    .ppuAddr    (ppuAddr),
    .prgRomAddr (prgRomAddr),
    .chrAddr    (chrAddr)
  );
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
  parameter int PRG_BANKS = 4,
  parameter int CHR_BANKS = 16,
  localparam int PRGW   = $clog2(PRG_BANKS),
  localparam int CHRW   = $clog2(CHR_BANKS),
  localparam int PRG_AW = PRGW + 15,
  localparam int CHR_AW = CHRW + 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeRegFile,
  input logic              compatEn,
  input logic [15:0]       cpuAddr,
  input logic [7:0]        cpuData,
  input logic              cpuWr,
  input logic [7:0]        romData,
  input logic [PRG_AW-1:0] prgRomAddr,
  input logic              wramEn,
  input logic              chrRamWe
);
  logic [PRGW-1:0] bankSeen;
  logic [7:0]      conflictVal;
  logic [PRGW-1:0] bit0Val;

  assign bankSeen    = prgRomAddr[PRG_AW-1:15];
  assign conflictVal = cpuData & romData;
  assign bit0Val     = PRGW'(cpuData[0]);

  // R2
  discrete_conflict_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeRegFile && cpuWr && cpuAddr[15]) |=> bankSeen == $past(conflictVal[PRGW-1:0]));

  // R3
  no_wram_discrete_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeRegFile |-> !wramEn);

  // R4
  strict_bit0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeRegFile && !compatEn && cpuWr && cpuAddr == 16'h7FFD) |=> bankSeen == $past(bit0Val));

  // R5
  chr_rom_no_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeRegFile |-> !chrRamWe);

  // R7
  strict_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeRegFile && !compatEn && cpuWr && cpuAddr[15]) |=> $stable(bankSeen));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWr |=> $stable(bankSeen));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeRegFile(modeRegFile),
  .compatEn   (compatEn),
  .cpuAddr    (cpuAddr),
  .cpuData    (cpuData),
  .cpuWr      (cpuWr),
  .romData    (romData),
  .prgRomAddr (prgRomAddr),
  .wramEn     (wramEn),
  .chrRamWe   (chrRamWe)
);

// File: tb/cart_bank_mapper_bench.sv
`timescale 1ns/1ps
module cart_bank_mapper_bench;
  localparam int PRG_BANKS = 4;
  localparam int CHR_BANKS = 16;
  localparam int PRGW = 2;
  localparam int CHRW = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              modeRegFile = 1'b0;
  logic              compatEn = 1'b0;
  logic [15:0]       cpuAddr = 16'h0000;
  logic [7:0]        cpuData = 8'h00;
  logic              cpuWr = 1'b0;
  logic [7:0]        romData = 8'h00;
  logic [12:0]       ppuAddr = 13'h0000;
  logic              ppuWr = 1'b0;
  logic [PRGW+14:0]  prgRomAddr;
  logic              prgRomEn;
  logic              wramEn;
  logic [CHRW+11:0]  chrAddr;
  logic              chrRamWe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cart_bank_mapper #(.PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS)) u_cart_bank_mapper (
    .clk(clk), .rstN(rstN), .modeRegFile(modeRegFile), .compatEn(compatEn),
    .cpuAddr(cpuAddr), .cpuData(cpuData), .cpuWr(cpuWr), .romData(romData),
    .ppuAddr(ppuAddr), .ppuWr(ppuWr), .prgRomAddr(prgRomAddr), .prgRomEn(prgRomEn),
    .wramEn(wramEn), .chrAddr(chrAddr), .chrRamWe(chrRamWe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic mode, input logic compat);
    @(negedge clk);
    rstN = 1'b0; cpuWr = 1'b0; ppuWr = 1'b0;
    modeRegFile = mode; compatEn = compat;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d, input logic [7:0] r);
    @(negedge clk);
    cpuAddr = a; cpuData = d; romData = r; cpuWr = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic expectPrg(input string req, input int bank);
    cpuAddr = 16'h8123; #1;
    chk(req, 32'(prgRomAddr), 32'((bank << 15) | 16'h0123));
  endtask

  task automatic expectChr(input string req, input logic [12:0] pa, input logic [31:0] exp);
    ppuAddr = pa; #1;
    chk(req, 32'(chrAddr), exp);
  endtask

  task automatic testDiscrete();
    doReset(1'b0, 1'b0);
    expectPrg("R9 discrete reset bank", 0);
    chk("R1 rom enable on read", 32'(prgRomEn), 1);
    cpuAddr = 16'h6010; #1;
    chk("R3 no wram", 32'(wramEn), 0);
    chk("R1 rom disabled below 8000", 32'(prgRomEn), 0);
    expectChr("R3 flat chr", 13'h1ABC, 32'h1ABC);
    ppuWr = 1'b1; #1;
    chk("R3 chr ram we", 32'(chrRamWe), 1);
    ppuWr = 1'b0;
    cpuWrite(16'h8000, 8'h03, 8'hFF);
    expectPrg("R2 write 3 rom ff", 3);
    cpuWrite(16'hA000, 8'h03, 8'h02);
    expectPrg("R2 and conflict", 2);
    cpuWrite(16'hFFFF, 8'h05, 8'hFF);
    expectPrg("R2 wrap modulo", 1);
    cpuWrite(16'h7FFD, 8'h03, 8'hFF);
    expectPrg("R3 wram window write ignored", 1);
    @(negedge clk);
    cpuAddr = 16'hC000; cpuWr = 1'b1; cpuData = 8'h00; romData = 8'h00; #1;
    chk("R1 rom enabled on discrete write", 32'(prgRomEn), 1);
    @(negedge clk); cpuWr = 1'b0;
    expectPrg("R2 write of zero", 0);
  endtask

  task automatic testStrict();
    doReset(1'b1, 1'b0);
    expectPrg("R9 reg reset bank", 0);
    expectChr("R9 lower chr default", 13'h0010, 32'h0010);
    expectChr("R9 upper chr default", 13'h1010, 32'h1010);
    cpuWrite(16'h7FFD, 8'h03, 8'h00);
    expectPrg("R4 bit0 of 3", 1);
    cpuWrite(16'h8000, 8'h02, 8'hFF);
    expectPrg("R7 upper write ignored", 1);
    cpuWrite(16'hFFFF, 8'h03, 8'hFF);
    expectPrg("R7 top write ignored", 1);
    cpuWrite(16'h7FFE, 8'd20, 8'h00);
    cpuWrite(16'h7FFF, 8'd15, 8'h00);
    expectPrg("R5 chr write keeps prg", 1);
    expectChr("R5 lower bank wraps", 13'h0234, 32'h4234);
    expectChr("R5 upper bank", 13'h1234, 32'hF234);
    ppuWr = 1'b1; #1;
    chk("R5 no chr write enable", 32'(chrRamWe), 0);
    ppuWr = 1'b0;
    cpuWrite(16'h7FFD, 8'h02, 8'h00);
    expectPrg("R4 bit0 of 2", 0);
    cpuAddr = 16'h7FFD; #1; chk("R6 wram at register", 32'(wramEn), 1);
    cpuAddr = 16'h6000; #1; chk("R6 wram base", 32'(wramEn), 1);
    cpuAddr = 16'h5FFF; #1; chk("R6 below window", 32'(wramEn), 0);
    cpuAddr = 16'h8000; #1; chk("R6 above window", 32'(wramEn), 0);
    @(negedge clk);
    cpuWr = 1'b1; cpuAddr = 16'h9000; #1;
    chk("R1 rom off on reg-mode write", 32'(prgRomEn), 0);
    @(negedge clk); cpuWr = 1'b0;
  endtask

  task automatic testCompat();
    doReset(1'b1, 1'b1);
    cpuWrite(16'h7FFD, 8'h03, 8'h00);
    expectPrg("R8 full byte at register", 3);
    cpuWrite(16'h8000, 8'h02, 8'h00);
    expectPrg("R8 upper write no masking", 2);
    cpuWrite(16'hFFFF, 8'h07, 8'h00);
    expectPrg("R8 wrap modulo", 3);
    cpuWrite(16'h7FFE, 8'h05, 8'h00);
    expectChr("R5 compat lower bank", 13'h0001, 32'h5001);
    doReset(1'b1, 1'b1);
    expectPrg("R9 reset after writes", 0);
    expectChr("R9 lower restored", 13'h0001, 32'h0001);
    expectChr("R9 upper restored", 13'h1001, 32'h1001);
  endtask

  task automatic testIdle();
    doReset(1'b1, 1'b1);
    @(negedge clk);
    cpuAddr = 16'h7FFD; cpuData = 8'h02; cpuWr = 1'b0;
    repeat (3) @(negedge clk);
    expectPrg("R10 no strobe no load", 0);
    cpuAddr = 16'h7FFE; ppuAddr = 13'h0000;
    repeat (3) @(negedge clk);
    #1; chk("R10 chr unchanged", 32'(chrAddr), 32'h0000);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testDiscrete();
    testStrict();
    testCompat();
    testIdle();
    finishRun();
  end
endmodule